// File: doc/BRIEF.md
# Logical Device I/O Activation and Range-Check Decoder

This block holds the control state of one logical device on a legacy host I/O bus: an activate bit, a range-check control with a pattern select, and a 16-bit I/O base address. A configuration controller writes and reads these registers through a byte-wide register port. The host issues I/O read cycles on a 16-bit address. The block decides whether the device answers a read, and what data it returns.

When the device is active, a read inside its window of `RANGE_LEN` consecutive ports is claimed. The returned byte comes from the device function through `dev_rdata_i`. When the device is inactive and range check is enabled, the block claims the same window but returns a fixed test byte. Configuration software can then find decode conflicts by looking for a corrupted pattern. The activate bit overrides the test mode, so an active device always decodes normally. A configuration-control reset pulse returns every register to zero.

Top module: `ldev_io_ctrl`

## Requirements
- R1: After `rst_ni` is deasserted, every register reads zero and `io_drive_o` is low with `io_rdata_o` zero.
- R2: Register address 0x30 holds the activate flag in bit 0. Bit 0 is written from `cfg_wdata_i[0]` and reads back, and bits [7:1] always read zero.
- R3: Register address 0x31 holds the pattern select in bit 0 and the range-check enable in bit 1. Both bits are writable and read back, and bits [7:2] always read zero.
- R4: Address 0x60 holds base bits [15:8] and address 0x61 holds base bits [7:0], both read/write. Every other register address reads zero, and writes to those addresses change no register.
- R5: A host read with the device active and the address in the window makes `io_drive_o` high, with `io_rdata_o` equal to the `dev_rdata_i` value present in the request cycle.
- R6: A host read in the window, with the device inactive and range check enabled, returns 0x55 when the pattern select is 1 and 0xAA when it is 0, with `io_drive_o` high.
- R7: When activate and range-check enable are both set, the test pattern is suppressed and the read is answered as in R5.
- R8: A read outside the window, or a read while the device is neither active nor in range check, leaves `io_drive_o` low and `io_rdata_o` zero.
- R9: The window is base to base+RANGE_LEN-1 inclusive and does not wrap past address 0xFFFF.
- R10: A pulse on `cfg_clr_i` clears activate, both range-check bits and the base to zero. It takes priority over a register write in the same cycle.
- R11: A response shows on the outputs in the cycle after the request cycle and lasts exactly one cycle for each single-cycle request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_clr_i | input | 1 | Configuration-control reset pulse |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data, combinational from `cfg_addr_i` |
| io_rd_i | input | 1 | Host I/O read request |
| io_addr_i | input | 16 | Host I/O address |
| dev_rdata_i | input | 8 | Byte supplied by the device function |
| io_drive_o | output | 1 | Block drives the host data bus |
| io_rdata_o | output | 8 | Byte returned to the host, zero when not driving |

## Verification
A register write takes effect at the clock edge that samples the strobe, and register read data is combinational. The bench therefore reads back one clock after each write, a little after the address settles. A host read sampled at edge k is answered in the cycle after edge k. The bench drives each request on a falling edge and compares both outputs on the next falling edge. It then checks one falling edge later that `io_drive_o` has dropped. The sweeps cover every register address and every mode combination, with addresses two ports below the window through two ports past it, on several bases that include the top of the address space.

// File: rtl/ldev_pkg.sv
`timescale 1ns/1ps
package ldev_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned IO_AW  = 16;

  localparam logic [7:0] ADDR_ACT     = 8'h30;
  localparam logic [7:0] ADDR_RCHK    = 8'h31;
  localparam logic [7:0] ADDR_BASE_HI = 8'h60;
  localparam logic [7:0] ADDR_BASE_LO = 8'h61;

  localparam logic [7:0] PAT_SEL_ONE  = 8'h55;
  localparam logic [7:0] PAT_SEL_ZERO = 8'hAA;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_FUNC  = 2'd1,
    MODE_PROBE = 2'd2
  } dec_mode_e;

  typedef struct packed {
    logic              act;
    logic              rc_en;
    logic              rc_sel;
    logic [IO_AW-1:0]  base;
  } ldev_cfg_t;
endpackage

// File: rtl/ldev_cfg_regs.sv
`timescale 1ns/1ps
module ldev_cfg_regs
  import ldev_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ldev_cfg_t        cfg_o
);
  localparam int unsigned HI_LSB = IO_AW - REG_W;

  ldev_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (clr_i) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_ACT:     cfg_q.act <= wdata_i[0];
        ADDR_RCHK: begin
          cfg_q.rc_sel <= wdata_i[0];
          cfg_q.rc_en  <= wdata_i[1];
        end
        ADDR_BASE_HI: cfg_q.base[IO_AW-1:HI_LSB] <= wdata_i;
        ADDR_BASE_LO: cfg_q.base[HI_LSB-1:0]     <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_ACT:     rdata_o[0]   = cfg_q.act;
      ADDR_RCHK:    rdata_o[1:0] = {cfg_q.rc_en, cfg_q.rc_sel};
      ADDR_BASE_HI: rdata_o      = cfg_q.base[IO_AW-1:HI_LSB];
      ADDR_BASE_LO: rdata_o      = cfg_q.base[HI_LSB-1:0];
      default:      rdata_o      = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  // R10
  clr_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cfg_q == '0));

  // R2
  act_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && addr_i == ADDR_ACT) |=> (cfg_q.act == $past(wdata_i[0])));

  // R3
  rchk_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && addr_i == ADDR_RCHK) |=>
      ({cfg_q.rc_en, cfg_q.rc_sel} == $past(wdata_i[1:0])));

  // R4
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(cfg_q));
endmodule

// File: rtl/ldev_range_match.sv
`timescale 1ns/1ps
module ldev_range_match
  import ldev_pkg::*;
#(
  parameter int unsigned RANGE_LEN = 8
) (
  input  logic [IO_AW-1:0] addr_i,
  input  logic [IO_AW-1:0] base_i,
  output logic             hit_o
);
  localparam int unsigned DW = IO_AW + 1;

  generate
    if (RANGE_LEN == 1) begin : g_single
      assign hit_o = (addr_i == base_i);
    end else begin : g_window
      logic [DW-1:0] diff;
      // widened subtract: negative offsets set the top bit, no wrap at 0xFFFF
      assign diff  = {1'b0, addr_i} - {1'b0, base_i};
      assign hit_o = !diff[DW-1] && (diff < DW'(RANGE_LEN));
    end
  endgenerate
endmodule

// File: rtl/ldev_resp.sv
`timescale 1ns/1ps
module ldev_resp
  import ldev_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             hit_i,
  input  ldev_cfg_t        cfg_i,
  input  logic [REG_W-1:0] dev_rdata_i,
  output logic             drive_o,
  output logic [REG_W-1:0] rdata_o
);
  dec_mode_e        mode;
  logic             claim;
  logic [REG_W-1:0] resp_d;
  logic             drive_q;
  logic [REG_W-1:0] rdata_q;

  // activate wins over the probe so an active device is never masked
  always_comb begin
    if (cfg_i.act)        mode = MODE_FUNC;
    else if (cfg_i.rc_en) mode = MODE_PROBE;
    else                  mode = MODE_IDLE;
  end

  assign claim = rd_i && hit_i && (mode != MODE_IDLE);

  always_comb begin
    unique case (mode)
      MODE_FUNC:  resp_d = dev_rdata_i;
      MODE_PROBE: resp_d = cfg_i.rc_sel ? PAT_SEL_ONE : PAT_SEL_ZERO;
      default:    resp_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      drive_q <= claim;
      rdata_q <= claim ? resp_d : '0;
    end
  end

  assign drive_o = drive_q;
  assign rdata_o = rdata_q;

  // R6
  probe_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_i && !cfg_i.act && cfg_i.rc_en) |=>
      (drive_q && (rdata_q == PAT_SEL_ONE || rdata_q == PAT_SEL_ZERO)));

  // R7
  func_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_i && cfg_i.act) |=> (drive_q && rdata_q == $past(dev_rdata_i)));

  // R8
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i || (!cfg_i.act && !cfg_i.rc_en)) |=> !drive_q);
endmodule

// File: rtl/ldev_io_ctrl.sv
`timescale 1ns/1ps
module ldev_io_ctrl
  import ldev_pkg::*;
#(
  parameter int unsigned RANGE_LEN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_clr_i,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  dev_rdata_i,
  output logic        io_drive_o,
  output logic [7:0]  io_rdata_o
);
  ldev_cfg_t cfg;
  logic      hit;

  ldev_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_clr_i),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  ldev_range_match #(.RANGE_LEN(RANGE_LEN)) u_match (
    .addr_i (io_addr_i),
    .base_i (cfg.base),
    .hit_o  (hit)
  );

  ldev_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (io_rd_i),
    .hit_i       (hit),
    .cfg_i       (cfg),
    .dev_rdata_i (dev_rdata_i),
    .drive_o     (io_drive_o),
    .rdata_o     (io_rdata_o)
  );

  // R11
  drive_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_drive_o |-> $past(io_rd_i));

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_drive_o |-> (io_rdata_o == 8'h00));
endmodule

// File: tb/tb_ldev_io_ctrl.sv
`timescale 1ns/1ps
module tb_ldev_io_ctrl;
  localparam int LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_clr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  dev_rdata = '0;
  logic        io_drive;
  logic [7:0]  io_rdata;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  ldev_io_ctrl #(.RANGE_LEN(LEN)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_clr_i   (cfg_clr),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .io_rd_i     (io_rd),
    .io_addr_i   (io_addr),
    .dev_rdata_i (dev_rdata),
    .io_drive_o  (io_drive),
    .io_rdata_o  (io_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, logic [7:0] exp, string req);
    cfg_addr = a;
    #0.5;
    chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  function automatic logic [15:0] base_of(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0300;
      2: return 16'h1234;
      3: return 16'hFFF8;
      default: return 16'hFFFC;
    endcase
  endfunction

  // one host read, checked in the cycle after the request and one cycle later
  task automatic host_read(logic [15:0] a, logic [7:0] dv, logic exp_drv,
                           logic [7:0] exp_dat, string req);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a; dev_rdata = dv;
    @(negedge clk);
    io_rd = 1'b0; dev_rdata = ~dv;
    chk({req, " drive"}, {31'h0, io_drive}, {31'h0, exp_drv});
    chk({req, " data"},  {24'h0, io_rdata}, {24'h0, exp_dat});
    @(negedge clk);
    chk("R11 one-cycle", {31'h0, io_drive}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 drive", {31'h0, io_drive}, 32'h0);
    chk("R1 data",  {24'h0, io_rdata}, 32'h0);
    for (int a = 0; a < 256; a++) rd_reg(8'(a), 8'h00, "R1 regs");

    // R2 R3 R4: write 0xFF to every address, then read the whole map
    for (int a = 0; a < 256; a++) wr(8'(a), 8'hFF);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      case (a)
        8'h30: e = 8'h01;
        8'h31: e = 8'h03;
        8'h60, 8'h61: e = 8'hFF;
        default: e = 8'h00;
      endcase
      rd_reg(8'(a), e, (a == 8'h30) ? "R2 act" : (a == 8'h31) ? "R3 rchk" : "R4 map");
    end
    wr(8'h30, 8'hFE); rd_reg(8'h30, 8'h00, "R2 clear");
    wr(8'h31, 8'hFD); rd_reg(8'h31, 8'h01, "R3 sel only");
    wr(8'h60, 8'hA5); rd_reg(8'h60, 8'hA5, "R4 hi");
    wr(8'h61, 8'h5A); rd_reg(8'h61, 8'h5A, "R4 lo");

    // R10 clear beats a simultaneous write
    wr(8'h30, 8'h01);
    @(negedge clk);
    cfg_clr = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h60; cfg_wdata = 8'h77;
    @(negedge clk);
    cfg_clr = 1'b0; cfg_we = 1'b0;
    rd_reg(8'h30, 8'h00, "R10 act");
    rd_reg(8'h31, 8'h00, "R10 rchk");
    rd_reg(8'h60, 8'h00, "R10 hi");
    rd_reg(8'h61, 8'h00, "R10 lo");
    host_read(16'h0000, 8'h11, 1'b0, 8'h00, "R10 quiet");

    // R5-R9 sweep: bases x modes x addresses around the window
    for (int b = 0; b < 5; b++) begin
      logic [15:0] base;
      base = base_of(b);
      wr(8'h60, base[15:8]);
      wr(8'h61, base[7:0]);
      for (int m = 0; m < 8; m++) begin
        logic act, en, sel;
        act = m[0]; en = m[1]; sel = m[2];
        wr(8'h30, {7'h0, act});
        wr(8'h31, {6'h0, en, sel});
        for (int off = -2; off < LEN + 2; off++) begin
          int          ai;
          logic [15:0] a;
          logic [7:0]  dv;
          logic        hit, ed;
          logic [7:0]  edat;
          string       req;
          ai = int'(base) + off;
          a  = 16'(ai);
          dv = a[7:0] ^ 8'h3C;
          hit = (ai >= 0) && (ai <= 16'hFFFF) &&
                (int'(a) >= int'(base)) && (int'(a) - int'(base) < LEN);
          ed = hit && (act || en);
          if (!ed)      edat = 8'h00;
          else if (act) edat = dv;
          else          edat = sel ? 8'h55 : 8'hAA;
          if (!hit)              req = (ai > 16'hFFFF || ai < 0) ? "R9 wrap" : "R8 miss";
          else if (act && en)    req = "R7 override";
          else if (act)          req = "R5 active";
          else if (en)           req = "R6 probe";
          else                   req = "R8 idle";
          host_read(a, dv, ed, edat, req);
        end
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule